// File: doc/BRIEF.md
# Serial Receiver Status Flags with Read-to-Clear

This block sits between a serial receiver core and a simple register bus. It holds the received byte and four status flags: receive-full, overrun, framing error and parity error. It also drives a receive interrupt and an error interrupt. The receiver core gives a one-cycle completion pulse for each byte, together with the sampled stop-bit level and a parity-mismatch indication. The bus side gives one-cycle read strobes for the status register and for the data register.

A flag is removed by a two-step sequence. First, a status read must happen while the flag is 1. That read arms the flag's clear. A later data read then clears every armed flag and disarms all of them. A data read with no armed flag leaves the flags unchanged. A status read that sees a flag at 0 does not arm that flag.

If a byte completes while receive-full is still pending, the overrun flag sets and the new byte is dropped. The data register keeps the earlier byte.

Top module: `uart_rx_flags`

## Requirements
- R1: While reset is active, and directly after it, the receive-full, overrun, framing and parity flags are 0 and the data output is 0.
- R2: A completion pulse with the stop-bit input at 0 sets the framing flag. The flag is visible after the clock edge that samples the pulse.
- R3: A completion pulse with the parity-mismatch input at 1 sets the parity flag. The flag is visible after the same edge.
- R4: A flag clears only when a data read follows an earlier status read that was taken while the flag was 1. A data read alone, or a data read after a status read that saw the flag at 0, leaves the flag unchanged.
- R5: Each data read disarms every flag. A later data read does not clear a flag that has set again unless a new status read has seen that flag at 1.
- R6: A byte that completes while receive-full is 0 is loaded into the data output and sets receive-full. If every byte is followed by a status read and then a data read, overrun stays 0.
- R7: A byte that completes while receive-full is 1, and is not being cleared in that cycle, sets overrun and is dropped. The data output and receive-full keep their values. A byte that completes in the same cycle as the data read that clears receive-full is accepted normally.
- R8: The error interrupt is 1 exactly when at least one of these holds: overrun and its enable are both 1, framing and its enable are both 1, or parity and its enable are both 1. The interrupt follows the flags and enables in the same cycle.
- R9: The receive interrupt equals receive-full AND its enable, in the same cycle.
- R10: If a flag's set event and its completing clear fall in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_done | input | 1 | One-cycle pulse when a byte completes |
| byte_in | input | DATA_W | Byte received with the pulse |
| stop_bit | input | 1 | Sampled stop-bit level for the completing frame |
| parity_bad | input | 1 | Parity mismatch for the completing frame |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| ie_rx | input | 1 | Receive interrupt enable |
| ie_ovr | input | 1 | Overrun interrupt enable |
| ie_frm | input | 1 | Framing interrupt enable |
| ie_par | input | 1 | Parity interrupt enable |
| rx_full | output | 1 | Receive-full flag |
| ovr_flag | output | 1 | Overrun flag |
| frm_flag | output | 1 | Framing-error flag |
| par_flag | output | 1 | Parity-error flag |
| data_out | output | DATA_W | Data register contents |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
Each flag, arm bit and the data register is one register stage. A pulse sampled at a rising edge therefore shows up on the flags and on data_out right after that edge, and the two interrupts follow from them with no further delay. The bench drives every strobe for exactly one cycle, starting at a falling edge. It reads the outputs at the next falling edge, which comes after the single edge that sampled the strobe. Enable changes are also checked at a falling edge, because the interrupts depend on the enables without any register in between.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int NFLAG = 4;

  typedef enum logic [1:0] {
    FL_FULL = 2'd0,
    FL_OVR  = 2'd1,
    FL_FRM  = 2'd2,
    FL_PAR  = 2'd3
  } flag_idx_e;

  // error request: OR of gated overrun, framing and parity
  function automatic logic err_request(input logic [NFLAG-1:0] flags,
                                       input logic [NFLAG-1:0] en);
    logic [NFLAG-1:0] g;
    g = flags & en;
    return g[FL_OVR] | g[FL_FRM] | g[FL_PAR];
  endfunction

  function automatic logic rx_request(input logic [NFLAG-1:0] flags,
                                      input logic [NFLAG-1:0] en);
    return flags[FL_FULL] & en[FL_FULL];
  endfunction
endpackage

// File: rtl/rxf_flag_cell.sv
module rxf_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic data_rd_i,
  output logic flag_o,
  output logic arm_o,
  output logic clr_o
);
  logic flag_q;
  logic arm_q;

  assign clr_o  = data_rd_i & arm_q;
  assign flag_o = flag_q;
  assign arm_o  = arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      // a new event wins over a clear in the same cycle
      if (set_i)      flag_q <= 1'b1;
      else if (clr_o) flag_q <= 1'b0;
      // a data read always consumes the arm
      if (data_rd_i)      arm_q <= 1'b0;
      else if (stat_rd_i) arm_q <= arm_q | flag_q;
    end
  end
endmodule

// File: rtl/rxf_data_hold.sv
module rxf_data_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_o <= '0;
    else if (load_i) data_o <= byte_i;
  end
endmodule

// File: rtl/rxf_irq_merge.sv
module rxf_irq_merge
  import rxf_pkg::*;
(
  input  logic [NFLAG-1:0] flags_i,
  input  logic [NFLAG-1:0] en_i,
  output logic             irq_rx_o,
  output logic             irq_err_o
);
  assign irq_rx_o  = rx_request(flags_i, en_i);
  assign irq_err_o = err_request(flags_i, en_i);
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stop_bit,
  input  logic              parity_bad,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              ie_rx,
  input  logic              ie_ovr,
  input  logic              ie_frm,
  input  logic              ie_par,
  output logic              rx_full,
  output logic              ovr_flag,
  output logic              frm_flag,
  output logic              par_flag,
  output logic [DATA_W-1:0] data_out,
  output logic              irq_rx,
  output logic              irq_err
);
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] flag_vec;
  logic [NFLAG-1:0] arm_vec;
  logic [NFLAG-1:0] clr_vec;
  logic [NFLAG-1:0] en_vec;

  // named internal events
  logic full_clr;
  logic accept_evt;
  logic overrun_evt;

  assign full_clr    = clr_vec[FL_FULL];
  assign accept_evt  = byte_done & (~flag_vec[FL_FULL] | full_clr);
  assign overrun_evt = byte_done & flag_vec[FL_FULL] & ~full_clr;

  assign set_vec[FL_FULL] = accept_evt;
  assign set_vec[FL_OVR]  = overrun_evt;
  assign set_vec[FL_FRM]  = byte_done & ~stop_bit;
  assign set_vec[FL_PAR]  = byte_done & parity_bad;

  assign en_vec[FL_FULL] = ie_rx;
  assign en_vec[FL_OVR]  = ie_ovr;
  assign en_vec[FL_FRM]  = ie_frm;
  assign en_vec[FL_PAR]  = ie_par;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    rxf_flag_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_vec[i]),
      .stat_rd_i (stat_rd),
      .data_rd_i (data_rd),
      .flag_o    (flag_vec[i]),
      .arm_o     (arm_vec[i]),
      .clr_o     (clr_vec[i])
    );
  end

  rxf_data_hold #(.W(DATA_W)) u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept_evt),
    .byte_i (byte_in),
    .data_o (data_out)
  );

  rxf_irq_merge u_irq (
    .flags_i   (flag_vec),
    .en_i      (en_vec),
    .irq_rx_o  (irq_rx),
    .irq_err_o (irq_err)
  );

  assign rx_full  = flag_vec[FL_FULL];
  assign ovr_flag = flag_vec[FL_OVR];
  assign frm_flag = flag_vec[FL_FRM];
  assign par_flag = flag_vec[FL_PAR];
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         byte_done,
  input logic         stop_bit,
  input logic         parity_bad,
  input logic         ie_rx,
  input logic         ie_ovr,
  input logic         ie_frm,
  input logic         ie_par,
  input logic         rx_full,
  input logic         ovr_flag,
  input logic         frm_flag,
  input logic         par_flag,
  input logic [W-1:0] data_out,
  input logic         irq_rx,
  input logic         irq_err,
  input logic [3:0]   clr_vec,
  input logic         full_clr
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rx_full && !ovr_flag && !frm_flag && !par_flag && data_out == '0); // R1

  AST_FRM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !stop_bit |=> frm_flag); // R2

  AST_PAR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && parity_bad |=> par_flag); // R3

  AST_FRM_CLR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frm_flag) |-> $past(clr_vec[2])); // R4

  AST_FULL_CLR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(clr_vec[0])); // R4

  AST_OVR_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && rx_full && !full_clr |=> ovr_flag && rx_full && $stable(data_out)); // R7

  AST_ERR_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_ovr && !ie_frm && !ie_par |-> !irq_err); // R8

  AST_RX_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> rx_full && ie_rx); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && parity_bad && clr_vec[3] |=> par_flag); // R10
endmodule

bind uart_rx_flags rxf_checker #(.W(DATA_W)) chk_i (.*);

// File: tb/uart_rx_flags_tb_top.sv
`timescale 1ns/1ps
module uart_rx_flags_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_done = 1'b0;
  logic [7:0] byte_in = '0;
  logic       stop_bit = 1'b1;
  logic       parity_bad = 1'b0;
  logic       stat_rd = 1'b0;
  logic       data_rd = 1'b0;
  logic       ie_rx = 1'b1, ie_ovr = 1'b1, ie_frm = 1'b1, ie_par = 1'b1;
  logic       rx_full, ovr_flag, frm_flag, par_flag, irq_rx, irq_err;
  logic [7:0] data_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_flags #(.DATA_W(8)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one-cycle drive; outputs are read at the falling edge after the sampling edge
  task automatic cyc(input logic bd, input logic [7:0] b, input logic sb,
                     input logic pb, input logic sr, input logic dr);
    @(negedge clk);
    byte_done = bd; byte_in = b; stop_bit = sb; parity_bad = pb;
    stat_rd = sr; data_rd = dr;
    @(negedge clk);
    byte_done = 0; stop_bit = 1; parity_bad = 0; stat_rd = 0; data_rd = 0;
  endtask

  task automatic rx_byte(input logic [7:0] b, input logic sb, input logic pb);
    cyc(1, b, sb, pb, 0, 0);
  endtask

  task automatic drain();
    cyc(0, 0, 1, 0, 1, 0);
    cyc(0, 0, 1, 0, 0, 1);
  endtask

  function automatic logic [3:0] flags();
    return {par_flag, frm_flag, ovr_flag, rx_full};
  endfunction

  task automatic t_reset();
    chk("R1 flags after reset", flags(), 4'b0000);
    chk("R1 data after reset", data_out, 8'h00);
  endtask

  task automatic t_normal();
    rx_byte(8'hA5, 1, 0);
    chk("R6 full set", rx_full, 1);
    chk("R6 data loaded", data_out, 8'hA5);
    drain();
    rx_byte(8'h3C, 1, 0);
    chk("R6 second byte", data_out, 8'h3C);
    drain();
    chk("R6 no overrun in normal flow", flags(), 4'b0000);
  endtask

  task automatic t_framing();
    rx_byte(8'h01, 0, 0);
    chk("R2 framing set", frm_flag, 1);
    chk("R8 err irq framing", irq_err, 1);
    @(negedge clk); ie_frm = 0; #1;
    chk("R8 err irq masked", irq_err, 0);
    ie_frm = 1;
    cyc(0, 0, 1, 0, 0, 1);
    chk("R4 data read alone keeps framing", frm_flag, 1);
    drain();
    chk("R4 framing cleared by sequence", frm_flag, 0);
  endtask

  task automatic t_parity();
    cyc(0, 0, 1, 0, 1, 0);
    rx_byte(8'h02, 1, 1);
    chk("R3 parity set", par_flag, 1);
    cyc(0, 0, 1, 0, 0, 1);
    chk("R4 stale status read does not arm", par_flag, 1);
    drain();
    chk("R4 parity cleared", flags(), 4'b0000);
    rx_byte(8'h03, 1, 1);
    cyc(0, 0, 1, 0, 1, 0);
    cyc(0, 0, 1, 0, 0, 1);
    rx_byte(8'h04, 1, 1);
    cyc(0, 0, 1, 0, 0, 1);
    chk("R5 arm used once, parity stays", par_flag, 1);
    chk("R5 arm used once, full stays", rx_full, 1);
    drain();
  endtask

  task automatic t_overrun();
    rx_byte(8'h11, 1, 0);
    rx_byte(8'h22, 1, 0);
    chk("R7 overrun set", ovr_flag, 1);
    chk("R7 data keeps old byte", data_out, 8'h11);
    chk("R7 full stays", rx_full, 1);
    chk("R8 err irq overrun", irq_err, 1);
    drain();
    chk("R7 all cleared", flags(), 4'b0000);
    rx_byte(8'h33, 1, 0);
    cyc(0, 0, 1, 0, 1, 0);
    cyc(1, 8'h44, 1, 0, 0, 1);
    chk("R7 same-cycle byte accepted", data_out, 8'h44);
    chk("R7 same-cycle no overrun", ovr_flag, 0);
    chk("R7 same-cycle full", rx_full, 1);
    drain();
  endtask

  task automatic t_set_wins();
    rx_byte(8'h55, 0, 0);
    cyc(0, 0, 1, 0, 1, 0);
    cyc(1, 8'h66, 0, 0, 0, 1);
    chk("R10 framing set wins", frm_flag, 1);
    chk("R10 full set wins", rx_full, 1);
    drain();
    chk("R10 cleanup", flags(), 4'b0000);
  endtask

  task automatic t_irq_rx();
    @(negedge clk); ie_rx = 0;
    rx_byte(8'h77, 1, 0);
    chk("R9 rx irq masked", irq_rx, 0);
    chk("R8 no err irq clean byte", irq_err, 0);
    @(negedge clk); ie_rx = 1; #1;
    chk("R9 rx irq enabled", irq_rx, 1);
    drain();
    chk("R9 rx irq after clear", irq_rx, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_framing();
    t_parity();
    t_overrun();
    t_set_wins();
    t_irq_rx();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule